// File: doc/BRIEF.md
# Atomic memory operation unit

This unit carries out one read-modify-write atomic operation on a memory word at a time. The caller presents the destination register value, a signed offset, the source register value, the current value of register zero, the 32-bit immediate that selects the sub-operation, and the access size (32-bit word or 64-bit double word). It then pulses `start`. The unit forms the effective address and checks it and the immediate. If both are legal, it issues a read over a request/response memory port and computes the new value. It then issues a write, unless a compare-and-exchange found no match. A lock output holds the memory locked for the whole sequence.

When the operation finishes, the unit pulses `done` for one cycle. In that cycle it gives the values to write back to the source register and to register zero, each with a write enable. An illegal immediate or an address that is not aligned to the access size finishes the operation at once with `err` set. In that case no memory request is made and no register is written.

Top module: `amo_unit`

## Requirements
- R1: The address on `mem_addr` for both the read and the write is `base` plus `offset` sign-extended, and it stays stable while `mem_lock` is high.
- R2: Immediate low byte 0x00 (add), 0x40 (or), 0x50 (and) or 0xa0 (xor) reads the word and then writes old op src. In word size only bits 31:0 of `mem_rdata`, the source and register zero take part, and bits 63:32 of `mem_wdata` are zero.
- R3: Immediate bit 0 is the fetch flag. With fetch set on a simple operation, `src_wen` is 1 and `src_out` is the old memory value zero-extended. With fetch clear, `src_wen` is 0.
- R4: Immediate 0xe1 (exchange) writes the source value to memory and returns the old memory value in `src_out` with `src_wen` = 1.
- R5: Immediate 0xf1 (compare-and-exchange) compares the old memory value with register zero and writes the source value only when they are equal. Whether or not they match, it sets `r0_wen` = 1 with `r0_out` = old value zero-extended, and `src_wen` = 0.
- R6: `mem_lock` is high from the read request up to and including the cycle of the last response: the write response, or the read response when no write follows. It is low at all other times.
- R7: Any immediate other than 0x00, 0x01, 0x40, 0x41, 0x50, 0x51, 0xa0, 0xa1, 0xe1 and 0xf1 (bits 31:8 must be zero) gives `done` with `err` = 1. No memory request is made and neither write enable is set.
- R8: A word access whose address has bits 1:0 nonzero, or a double-word access whose address has bits 2:0 nonzero, gives `done` with `err` = 1 and makes no memory request.
- R9: `done` is a single-cycle pulse, and `mem_lock` is low in that cycle.
- R10: After reset, `mem_req`, `mem_lock` and `done` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| start | input | 1 | Begin an operation (sampled when idle) |
| dw | input | 1 | Access size: 1 = 64-bit, 0 = 32-bit |
| imm | input | IMM_W | Immediate selecting the sub-operation |
| base | input | XLEN | Destination register value |
| offset | input | OFF_W | Signed address offset |
| src_val | input | XLEN | Source register value |
| r0_val | input | XLEN | Register zero value |
| mem_req | output | 1 | One-cycle memory request |
| mem_we | output | 1 | Request is a write |
| mem_lock | output | 1 | Memory locked for this sequence |
| mem_size | output | 1 | Access size of the request |
| mem_addr | output | XLEN | Request address |
| mem_wdata | output | XLEN | Write data |
| mem_ack | input | 1 | Response for the outstanding request |
| mem_rdata | input | XLEN | Read response data |
| done | output | 1 | Operation finished (one cycle) |
| err | output | 1 | Operation rejected |
| src_wen | output | 1 | Write `src_out` to the source register |
| src_out | output | XLEN | New source register value |
| r0_wen | output | 1 | Write `r0_out` to register zero |
| r0_out | output | XLEN | New register zero value |

## Verification
The bench targets word-size operations whose memory image carries unrelated upper bits. A unit that did not mask by size would either carry an add out of bit 31 or compare register zero across all 64 bits, and would then corrupt the upper half or wrongly refuse a match. Compare-and-exchange is run both with a match and without one: a faulty unit would write on a mismatch or leave register zero unwritten. Exchange without the fetch flag, nonzero upper immediate bits, a negative offset, and addresses misaligned for only one of the two sizes are also covered; a wrong decode or alignment test would touch memory when it must not. Response latency varies from one operation to the next, so a lock that dropped early or a unit that did not wait for the response would show up.

// File: rtl/amo_pkg.sv
package amo_pkg;
   typedef enum logic [2:0] {
      AMO_ADD  = 3'd0,
      AMO_OR   = 3'd1,
      AMO_AND  = 3'd2,
      AMO_XOR  = 3'd3,
      AMO_SWAP = 3'd4,
      AMO_CAS  = 3'd5
   } amo_op_e;

   typedef enum logic [2:0] {
      ST_IDLE  = 3'd0,
      ST_RREQ  = 3'd1,
      ST_RWAIT = 3'd2,
      ST_WREQ  = 3'd3,
      ST_WWAIT = 3'd4,
      ST_FIN   = 3'd5
   } amo_state_e;

   localparam logic [7:0] CODE_ADD  = 8'h00;
   localparam logic [7:0] CODE_OR   = 8'h40;
   localparam logic [7:0] CODE_AND  = 8'h50;
   localparam logic [7:0] CODE_XOR  = 8'ha0;
   localparam logic [7:0] CODE_SWAP = 8'he0;
   localparam logic [7:0] CODE_CAS  = 8'hf0;
endpackage

// File: rtl/amo_decode.sv
module amo_decode
   import amo_pkg::*;
#(
   parameter int IMM_W = 32
) (
   input  logic [IMM_W-1:0] imm,
   output amo_op_e          op,
   output logic             fetch,
   output logic             legal
);
   logic [7:0] code;
   logic       hi_zero;

   initial assert (IMM_W > 8) else $error("amo_decode: IMM_W must exceed 8");

   assign code    = {imm[7:1], 1'b0};
   assign fetch   = imm[0];
   assign hi_zero = (imm[IMM_W-1:8] == '0);

   always_comb begin
      op    = AMO_ADD;
      legal = 1'b0;
      case (code)
         CODE_ADD:  begin op = AMO_ADD;  legal = hi_zero;         end
         CODE_OR:   begin op = AMO_OR;   legal = hi_zero;         end
         CODE_AND:  begin op = AMO_AND;  legal = hi_zero;         end
         CODE_XOR:  begin op = AMO_XOR;  legal = hi_zero;         end
         CODE_SWAP: begin op = AMO_SWAP; legal = hi_zero & fetch; end
         CODE_CAS:  begin op = AMO_CAS;  legal = hi_zero & fetch; end
         default:   begin op = AMO_ADD;  legal = 1'b0;            end
      endcase
   end
endmodule

// File: rtl/amo_alu.sv
module amo_alu
   import amo_pkg::*;
#(
   parameter int XLEN = 64
) (
   input  amo_op_e         op,
   input  logic            dw,
   input  logic [XLEN-1:0] rdata,
   input  logic [XLEN-1:0] src,
   input  logic [XLEN-1:0] r0,
   output logic [XLEN-1:0] old_ext,
   output logic [XLEN-1:0] new_val,
   output logic            do_write
);
   localparam int HALF = XLEN / 2;

   logic [XLEN-1:0] mask, src_m, r0_m, raw;

   generate
      if (XLEN % 2 == 0) begin : g_even
         assign mask = dw ? {XLEN{1'b1}} : {{HALF{1'b0}}, {HALF{1'b1}}};
      end else begin : g_odd
         assign mask = {XLEN{1'b1}};
      end
   endgenerate

   assign old_ext = rdata & mask;
   assign src_m   = src & mask;
   assign r0_m    = r0 & mask;

   always_comb begin
      case (op)
         AMO_ADD:  raw = old_ext + src_m;
         AMO_OR:   raw = old_ext | src_m;
         AMO_AND:  raw = old_ext & src_m;
         AMO_XOR:  raw = old_ext ^ src_m;
         default:  raw = src_m;
      endcase
   end

   assign new_val  = raw & mask;
   assign do_write = (op != AMO_CAS) || (old_ext == r0_m);
endmodule

// File: rtl/amo_unit.sv
module amo_unit
   import amo_pkg::*;
#(
   parameter int XLEN  = 64,
   parameter int OFF_W = 16,
   parameter int IMM_W = 32
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             start,
   input  logic             dw,
   input  logic [IMM_W-1:0] imm,
   input  logic [XLEN-1:0]  base,
   input  logic [OFF_W-1:0] offset,
   input  logic [XLEN-1:0]  src_val,
   input  logic [XLEN-1:0]  r0_val,
   output logic             mem_req,
   output logic             mem_we,
   output logic             mem_lock,
   output logic             mem_size,
   output logic [XLEN-1:0]  mem_addr,
   output logic [XLEN-1:0]  mem_wdata,
   input  logic             mem_ack,
   input  logic [XLEN-1:0]  mem_rdata,
   output logic             done,
   output logic             err,
   output logic             src_wen,
   output logic [XLEN-1:0]  src_out,
   output logic             r0_wen,
   output logic [XLEN-1:0]  r0_out
);
   localparam int ALIGN_DW = $clog2(XLEN / 8);
   localparam int ALIGN_W  = ALIGN_DW - 1;

   initial assert (XLEN == 64 || XLEN == 32) else $error("amo_unit: XLEN must be 32 or 64");
   initial assert (OFF_W <= XLEN) else $error("amo_unit: OFF_W wider than XLEN");

   amo_state_e      state;
   amo_op_e         dec_op, op_q;
   logic            dec_fetch, dec_legal;
   logic            fetch_q, dw_q;
   logic [XLEN-1:0] eff, addr_q, src_q, r0_q, wdata_q;
   logic            misalign;
   logic [XLEN-1:0] alu_old, alu_new;
   logic            alu_wr;

   amo_decode #(.IMM_W(IMM_W)) u_dec (
      .imm   (imm),
      .op    (dec_op),
      .fetch (dec_fetch),
      .legal (dec_legal)
   );

   amo_alu #(.XLEN(XLEN)) u_alu (
      .op       (op_q),
      .dw       (dw_q),
      .rdata    (mem_rdata),
      .src      (src_q),
      .r0       (r0_q),
      .old_ext  (alu_old),
      .new_val  (alu_new),
      .do_write (alu_wr)
   );

   assign eff      = base + {{(XLEN-OFF_W){offset[OFF_W-1]}}, offset};
   assign misalign = dw ? (|eff[ALIGN_DW-1:0]) : (|eff[ALIGN_W-1:0]);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state   <= ST_IDLE;
         op_q    <= AMO_ADD;
         fetch_q <= 1'b0;
         dw_q    <= 1'b0;
         addr_q  <= '0;
         src_q   <= '0;
         r0_q    <= '0;
         wdata_q <= '0;
         err     <= 1'b0;
         src_wen <= 1'b0;
         src_out <= '0;
         r0_wen  <= 1'b0;
         r0_out  <= '0;
      end else begin
         case (state)
            ST_IDLE: if (start) begin
               op_q    <= dec_op;
               fetch_q <= dec_fetch;
               dw_q    <= dw;
               addr_q  <= eff;
               src_q   <= src_val;
               r0_q    <= r0_val;
               src_wen <= 1'b0;
               r0_wen  <= 1'b0;
               if (!dec_legal || misalign) begin
                  err   <= 1'b1;
                  state <= ST_FIN;
               end else begin
                  err   <= 1'b0;
                  state <= ST_RREQ;
               end
            end
            ST_RREQ: state <= ST_RWAIT;
            ST_RWAIT: if (mem_ack) begin
               wdata_q <= alu_new;
               src_out <= alu_old;
               r0_out  <= alu_old;
               src_wen <= fetch_q && (op_q != AMO_CAS);
               r0_wen  <= (op_q == AMO_CAS);
               state   <= alu_wr ? ST_WREQ : ST_FIN;
            end
            ST_WREQ: state <= ST_WWAIT;
            ST_WWAIT: if (mem_ack) state <= ST_FIN;
            default: state <= ST_IDLE;
         endcase
      end
   end

   assign mem_req   = (state == ST_RREQ) || (state == ST_WREQ);
   assign mem_we    = (state == ST_WREQ);
   assign mem_lock  = (state == ST_RREQ) || (state == ST_RWAIT) ||
                      (state == ST_WREQ) || (state == ST_WWAIT);
   assign mem_size  = dw_q;
   assign mem_addr  = addr_q;
   assign mem_wdata = wdata_q;
   assign done      = (state == ST_FIN);
endmodule

// File: rtl/amo_unit_chk.sv
module amo_unit_chk #(
   parameter int XLEN = 64
) (
   input logic            clk,
   input logic            rst_n,
   input logic            mem_req,
   input logic            mem_we,
   input logic            mem_lock,
   input logic [XLEN-1:0] mem_addr,
   input logic            done,
   input logic            err,
   input logic            src_wen,
   input logic            r0_wen
);
   a_r6_req_locked: assert property (@(posedge clk) disable iff (!rst_n)
      mem_req |-> mem_lock);

   a_r6_write_after_lock: assert property (@(posedge clk) disable iff (!rst_n)
      (mem_req && mem_we) |-> $past(mem_lock));

   a_r1_addr_stable: assert property (@(posedge clk) disable iff (!rst_n)
      (mem_lock && $past(mem_lock)) |-> $stable(mem_addr));

   a_r9_done_unlocked: assert property (@(posedge clk) disable iff (!rst_n)
      done |-> !mem_lock);

   a_r9_done_pulse: assert property (@(posedge clk) disable iff (!rst_n)
      done |=> !done);

   a_r7_err_no_wen: assert property (@(posedge clk) disable iff (!rst_n)
      (done && err) |-> (!src_wen && !r0_wen));

   a_r5_cas_no_src: assert property (@(posedge clk) disable iff (!rst_n)
      (done && r0_wen) |-> !src_wen);
endmodule

bind amo_unit amo_unit_chk #(.XLEN(XLEN)) u_chk (
   .clk      (clk),
   .rst_n    (rst_n),
   .mem_req  (mem_req),
   .mem_we   (mem_we),
   .mem_lock (mem_lock),
   .mem_addr (mem_addr),
   .done     (done),
   .err      (err),
   .src_wen  (src_wen),
   .r0_wen   (r0_wen)
);

// File: tb/amo_unit_test.sv
module amo_unit_test;
   typedef struct packed {
      logic [31:0] imm;
      logic        dw;
      logic [63:0] base;
      logic [15:0] off;
      logic [63:0] src;
      logic [63:0] r0;
      logic [63:0] mem0;
      logic [63:0] exp_mem;
      logic        err;
      logic        src_wen;
      logic [63:0] src_exp;
      logic        r0_wen;
      logic [63:0] r0_exp;
      logic        wrote;
   } vec_t;

   localparam int NV = 16;
   localparam vec_t VEC [NV] = '{
      // R2 add dword
      '{32'h00, 1'b1, 64'h1000, 16'h0008, 64'h5, 64'h0, 64'h10, 64'h15, 1'b0, 1'b0, 64'h0, 1'b0, 64'h0, 1'b1},
      // R2 R3 add word with fetch, carry out of bit 31 dropped
      '{32'h01, 1'b0, 64'h1000, 16'h0008, 64'h2, 64'h0, 64'hDEADBEEF_FFFFFFFF, 64'hDEADBEEF_00000001, 1'b0, 1'b1, 64'h00000000_FFFFFFFF, 1'b0, 64'h0, 1'b1},
      // R2 R3 or fetch
      '{32'h41, 1'b1, 64'h1000, 16'h0008, 64'h0F00000000000F0F, 64'h0, 64'hF0F0, 64'h0F0000000000FFFF, 1'b0, 1'b1, 64'hF0F0, 1'b0, 64'h0, 1'b1},
      // R2 and
      '{32'h50, 1'b1, 64'h1000, 16'h0008, 64'h0FF00FF00FF00FF0, 64'h0, 64'hFF00FF00FF00FF00, 64'h0F000F000F000F00, 1'b0, 1'b0, 64'h0, 1'b0, 64'h0, 1'b1},
      // R2 R3 xor fetch
      '{32'hA1, 1'b1, 64'h1000, 16'h0008, 64'hFFFFFFFF0000FFFF, 64'h0, 64'hAAAAAAAA55555555, 64'h555555555555AAAA, 1'b0, 1'b1, 64'hAAAAAAAA55555555, 1'b0, 64'h0, 1'b1},
      // R4 exchange
      '{32'hE1, 1'b1, 64'h1000, 16'h0008, 64'h2222, 64'h0, 64'h1111, 64'h2222, 1'b0, 1'b1, 64'h1111, 1'b0, 64'h0, 1'b1},
      // R5 cas match
      '{32'hF1, 1'b1, 64'h1000, 16'h0008, 64'h99, 64'h77, 64'h77, 64'h99, 1'b0, 1'b0, 64'h0, 1'b1, 64'h77, 1'b1},
      // R5 cas mismatch: no write
      '{32'hF1, 1'b1, 64'h1000, 16'h0008, 64'h99, 64'h76, 64'h77, 64'h77, 1'b0, 1'b0, 64'h0, 1'b1, 64'h77, 1'b0},
      // R5 cas word: only low halves compared
      '{32'hF1, 1'b0, 64'h1000, 16'h0008, 64'h55550000000000AB, 64'hFFFFFFFF12345678, 64'hCAFE000012345678, 64'hCAFE0000000000AB, 1'b0, 1'b0, 64'h0, 1'b1, 64'h12345678, 1'b1},
      // R1 negative offset
      '{32'h00, 1'b1, 64'h2000, 16'hFFF8, 64'h1, 64'h0, 64'h1, 64'h2, 1'b0, 1'b0, 64'h0, 1'b0, 64'h0, 1'b1},
      // R7 unknown code
      '{32'h02, 1'b1, 64'h1000, 16'h0008, 64'h1, 64'h0, 64'h1234, 64'h1234, 1'b1, 1'b0, 64'h0, 1'b0, 64'h0, 1'b0},
      // R7 exchange without fetch
      '{32'hE0, 1'b1, 64'h1000, 16'h0008, 64'h1, 64'h0, 64'h1234, 64'h1234, 1'b1, 1'b0, 64'h0, 1'b0, 64'h0, 1'b0},
      // R8 dword at 4-byte boundary
      '{32'h00, 1'b1, 64'h1000, 16'h0004, 64'h1, 64'h0, 64'h1234, 64'h1234, 1'b1, 1'b0, 64'h0, 1'b0, 64'h0, 1'b0},
      // R8 word at 2-byte boundary
      '{32'h00, 1'b0, 64'h1000, 16'h0002, 64'h1, 64'h0, 64'h1234, 64'h1234, 1'b1, 1'b0, 64'h0, 1'b0, 64'h0, 1'b0},
      // R8 word at 4-byte boundary is legal, xor no fetch
      '{32'hA0, 1'b0, 64'h1000, 16'h0004, 64'h0F, 64'h0, 64'hFF, 64'hF0, 1'b0, 1'b0, 64'h0, 1'b0, 64'h0, 1'b1},
      // R7 upper immediate bits set
      '{32'h100, 1'b1, 64'h1000, 16'h0008, 64'h1, 64'h0, 64'h1234, 64'h1234, 1'b1, 1'b0, 64'h0, 1'b0, 64'h0, 1'b0}
   };

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        start = 1'b0;
   logic        dw = 1'b0;
   logic [31:0] imm = '0;
   logic [63:0] base = '0;
   logic [15:0] offset = '0;
   logic [63:0] src_val = '0;
   logic [63:0] r0_val = '0;
   logic        mem_req, mem_we, mem_lock, mem_size;
   logic [63:0] mem_addr, mem_wdata;
   logic        mem_ack = 1'b0;
   logic [63:0] mem_rdata = '0;
   logic        done, err, src_wen, r0_wen;
   logic [63:0] src_out, r0_out;

   int checks = 0;
   int fails  = 0;

   always #5 clk = ~clk;

   amo_unit uut (
      .clk(clk), .rst_n(rst_n), .start(start), .dw(dw), .imm(imm),
      .base(base), .offset(offset), .src_val(src_val), .r0_val(r0_val),
      .mem_req(mem_req), .mem_we(mem_we), .mem_lock(mem_lock),
      .mem_size(mem_size), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
      .mem_ack(mem_ack), .mem_rdata(mem_rdata), .done(done), .err(err),
      .src_wen(src_wen), .src_out(src_out), .r0_wen(r0_wen), .r0_out(r0_out)
   );

   task automatic check(input string req, input int idx, input string what,
                        input logic [63:0] got, input logic [63:0] exp);
      checks++;
      if (got !== exp) begin
         fails++;
         $display("FAIL %s vec %0d %s: got %h expected %h", req, idx, what, got, exp);
      end
   endtask

   task automatic run_vec(input int i);
      logic [63:0] memw, exp_addr, wd;
      logic        pend, is_wr, started, saw_access, lock_bad, addr_bad, hi_bad, got_done;
      int          cnt;
      vec_t        v;
      v = VEC[i];
      memw = v.mem0;
      exp_addr = v.base + {{48{v.off[15]}}, v.off};
      pend = 1'b0; is_wr = 1'b0; started = 1'b0; saw_access = 1'b0;
      lock_bad = 1'b0; addr_bad = 1'b0; hi_bad = 1'b0; got_done = 1'b0;
      cnt = 0; wd = '0;
      @(negedge clk);
      imm = v.imm; dw = v.dw; base = v.base; offset = v.off;
      src_val = v.src; r0_val = v.r0; start = 1'b1;
      @(negedge clk);
      start = 1'b0;
      for (int k = 0; k < 60; k++) begin
         mem_ack = 1'b0;
         if (done) begin
            got_done = 1'b1;
            break;
         end
         if (started && !mem_lock) lock_bad = 1'b1;
         if (mem_req) begin
            started = 1'b1; saw_access = 1'b1;
            if (!mem_lock) lock_bad = 1'b1;
            if (mem_addr !== exp_addr) addr_bad = 1'b1;
            is_wr = mem_we; wd = mem_wdata; pend = 1'b1;
            cnt = (i % 3) + 1;
         end else if (pend) begin
            cnt--;
            if (cnt == 0) begin
               mem_ack = 1'b1;
               pend = 1'b0;
               if (is_wr) begin
                  if (!v.dw && (wd[63:32] != 32'h0)) hi_bad = 1'b1;
                  memw = v.dw ? wd : {memw[63:32], wd[31:0]};
               end else begin
                  mem_rdata = memw;
               end
            end
         end
         @(negedge clk);
      end
      check("R9", i, "done seen", {63'h0, got_done}, 64'h1);
      check("R9", i, "lock low at done", {63'h0, mem_lock}, 64'h0);
      check(v.err ? "R7/R8" : "R2", i, "err", {63'h0, err}, {63'h0, v.err});
      check(v.err ? "R7/R8" : "R2", i, "memory access made", {63'h0, saw_access}, {63'h0, !v.err});
      check(v.wrote ? "R2" : "R5", i, "memory word", memw, v.exp_mem);
      check("R3", i, "src_wen", {63'h0, src_wen}, {63'h0, v.src_wen});
      if (v.src_wen) check("R4", i, "src_out", src_out, v.src_exp);
      check("R5", i, "r0_wen", {63'h0, r0_wen}, {63'h0, v.r0_wen});
      if (v.r0_wen) check("R5", i, "r0_out", r0_out, v.r0_exp);
      if (!v.err) begin
         check("R1", i, "address mismatch", {63'h0, addr_bad}, 64'h0);
         check("R6", i, "lock gap", {63'h0, lock_bad}, 64'h0);
         check("R2", i, "word upper wdata", {63'h0, hi_bad}, 64'h0);
      end
   endtask

   initial begin
      #2_000_000;
      fails++;
      $display("FAIL watchdog: run hung, got timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
   end

   initial begin
      repeat (3) @(negedge clk);
      // R10 reset state
      check("R10", -1, "mem_req", {63'h0, mem_req}, 64'h0);
      check("R10", -1, "mem_lock", {63'h0, mem_lock}, 64'h0);
      check("R10", -1, "done", {63'h0, done}, 64'h0);
      rst_n = 1'b1;
      @(negedge clk);
      check("R10", -1, "idle after release", {62'h0, mem_req, done}, 64'h0);
      for (int i = 0; i < NV; i++) run_vec(i);
      // R9 done is a one-cycle pulse: after the last operation it stays low
      @(negedge clk);
      check("R9", -1, "done after pulse", {63'h0, done}, 64'h0);
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
   end
endmodule